// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block records the cache lines read by loads that a core has executed ahead of program order and not yet retired. While it holds them, it watches the coherence traffic for writes from other agents. An out-of-order core uses it to keep the appearance of strictly ordered memory. The issue stage allocates an entry for each speculative load, giving the load address and an age tag. The retire stage takes entries off the oldest end, one per cycle. A snoop port carries the line address of each remote store or invalidation.

When a snoop lands on a line held by a live entry, that entry is marked as suspect. The mark stays until the entry leaves the table. When a marked entry reaches retirement, the block does not retire it quietly. It pulses a squash request that carries the load's age tag and empties the whole table, so the pipeline can re-execute from that load onward. Stores never enter the table.

Top module: `spec_load_tracker`

## Requirements
- R1: After a synchronous active-low reset, `alloc_ready` is 1, `head_valid` is 0 and `squash_valid` is 0.
- R2: An accepted allocation is written at the young end of a circular table. `head_tag` always shows the tag of the oldest live entry. Each `commit_valid` with `head_valid` high removes that entry, so tags leave in allocation order.
- R3: The table holds 8 entries. With 8 live, `alloc_ready` is 0 and an `alloc_valid` request is dropped without changing the table.
- R4: Addresses match on bits [31:6] only, which gives 64-byte lines. A snoop that differs only in bits [5:0] hits. A snoop that differs in bit 6 or any higher bit does not hit.
- R5: One snoop marks every live entry holding its line, in the cycle it arrives. The mark stays through later non-matching snoops until the entry leaves the table.
- R6: A snoop and an accepted allocation of the same line in the same cycle mark the new entry.
- R7: A commit of a marked oldest entry raises `squash_valid` for exactly one cycle, starting in the cycle after the commit. `squash_tag` in that cycle equals the committed entry's tag. The table is empty in the same cycle.
- R8: A snoop that matches the oldest entry in the same cycle as its commit also causes a squash.
- R9: A `commit_valid` while the table is empty has no effect. An allocation in the same cycle as a squashing commit is discarded.
- R10: A commit of an unmarked entry produces no squash and leaves younger entries in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Speculative load requests an entry |
| alloc_addr | input | 32 | Load byte address |
| alloc_tag | input | 6 | Age tag of the load |
| alloc_ready | output | 1 | Table has a free entry |
| commit_valid | input | 1 | Retire the oldest entry |
| head_valid | output | 1 | Table holds at least one entry |
| head_tag | output | 6 | Tag of the oldest entry |
| snoop_valid | input | 1 | Remote store or invalidation observed |
| snoop_addr | input | 32 | Byte address of the remote event |
| squash_valid | output | 1 | One-cycle squash request |
| squash_tag | output | 6 | Tag of the load to squash from |

## Verification
Loads are allocated and retired with no snoops, to confirm ordered retirement with no false squash. The table is filled to capacity, to tell a refused request apart from a lost one. Snoops are sent that differ from a held line only in the byte offset, and others that differ in bit 6 or in the top bits, which separates line matching from full-address matching. Snoops are also timed to fall in the same cycle as an allocation or as the retirement of the matching load, and to hit several entries at once. These cases show whether a same-cycle event is caught and whether the flush clears every mark. Long runs of back-to-back allocate-and-retire cycles walk the pointers around the ring.

// File: rtl/slt_pkg.sv
// Shared constants and types for the speculative load tracker.
package slt_pkg;
    localparam int SLT_ADDR_W     = 32;
    localparam int SLT_TAG_W      = 6;
    localparam int SLT_DEPTH      = 8;
    localparam int SLT_LINE_BYTES = 64;

    // Outcome of the retire port in one cycle.
    typedef enum logic [1:0] {
        RET_NONE   = 2'd0,
        RET_CLEAN  = 2'd1,
        RET_SQUASH = 2'd2
    } retire_kind_t;
endpackage

// File: rtl/slt_age_ring.sv
// Circular age pointers for the tracker table.
// Push writes at tail, pop frees head, flush empties the ring.
// Assumes the caller never pushes when full or pops when empty.
module slt_age_ring #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    logic [CNT_W-1:0] count_q;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_idx <= '0;
            tail_idx <= '0;
            count_q  <= '0;
        end else begin
            if (push) tail_idx <= bump(tail_idx);
            if (pop)  head_idx <= bump(head_idx);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Occupancy flags.
    always_comb begin
        full  = (count_q == CNT_W'(DEPTH));
        empty = (count_q == '0);
    end
endmodule

// File: rtl/slt_line_cmp.sv
// Parallel line-address comparator.
// Reports which live slots hold the probed line. Assumes lines are already
// stripped of their byte-offset bits.
module slt_line_cmp #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 26
) (
    input  logic                          probe_valid,
    input  logic [LINE_W-1:0]             probe_line,
    input  logic [DEPTH-1:0][LINE_W-1:0]  slot_line,
    input  logic [DEPTH-1:0]              slot_live,
    output logic [DEPTH-1:0]              slot_hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // One comparator per slot.
        always_comb slot_hit[g] = probe_valid && slot_live[g] &&
                                  (slot_line[g] == probe_line);
    end
endmodule

// File: rtl/spec_load_tracker.sv
// Speculative load address tracker.
// Holds the line address and age tag of each speculatively executed load
// until it retires. Remote snoops mark matching entries. Retiring a marked
// entry emits a one-cycle squash and empties the table.
// Assumes allocation order equals age order, one alloc, one retire and one
// snoop per cycle.
module spec_load_tracker
    import slt_pkg::*;
#(
    parameter int ADDR_W     = SLT_ADDR_W,
    parameter int TAG_W      = SLT_TAG_W,
    parameter int DEPTH      = SLT_DEPTH,
    parameter int LINE_BYTES = SLT_LINE_BYTES,
    localparam int LINE_OFF  = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - LINE_OFF,
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    input  logic              commit_valid,
    output logic              head_valid,
    output logic [TAG_W-1:0]  head_tag,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              squash_valid,
    output logic [TAG_W-1:0]  squash_tag
);
    logic [DEPTH-1:0][LINE_W-1:0] line_q;
    logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
    logic [DEPTH-1:0]             live_q;
    logic [DEPTH-1:0]             mark_q;
    logic [DEPTH-1:0]             snoop_hit;

    logic [PTR_W-1:0] head_idx, tail_idx;
    logic             ring_full, ring_empty;
    logic             commit_fire, alloc_fire, new_line_hit;
    logic [LINE_W-1:0] snoop_line, alloc_line;
    retire_kind_t     retire;

    // Line addresses of the two incoming streams.
    always_comb begin
        snoop_line = snoop_addr[ADDR_W-1:LINE_OFF];
        alloc_line = alloc_addr[ADDR_W-1:LINE_OFF];
    end

    slt_line_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp (
        .probe_valid (snoop_valid),
        .probe_line  (snoop_line),
        .slot_line   (line_q),
        .slot_live   (live_q),
        .slot_hit    (snoop_hit)
    );

    // Retire decision, including a snoop on the head in the same cycle.
    always_comb begin
        commit_fire = commit_valid && !ring_empty;
        if (!commit_fire)
            retire = RET_NONE;
        else if (mark_q[head_idx] || snoop_hit[head_idx])
            retire = RET_SQUASH;
        else
            retire = RET_CLEAN;
        alloc_fire   = alloc_valid && !ring_full && (retire != RET_SQUASH);
        new_line_hit = snoop_valid && (snoop_line == alloc_line);
    end

    slt_age_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_fire),
        .pop      (commit_fire),
        .flush    (retire == RET_SQUASH),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (ring_full),
        .empty    (ring_empty)
    );

    // Entry payload capture on allocation.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            line_q[tail_idx] <= alloc_line;
            tag_q[tail_idx]  <= alloc_tag;
        end
    end

    // Live and mark bits: sticky snoop marks, retire, allocate, flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            mark_q <= '0;
        end else if (retire == RET_SQUASH) begin
            live_q <= '0;
            mark_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (snoop_hit[i]) mark_q[i] <= 1'b1;
            end
            if (commit_fire) begin
                live_q[head_idx] <= 1'b0;
                mark_q[head_idx] <= 1'b0;
            end
            if (alloc_fire) begin
                live_q[tail_idx] <= 1'b1;
                mark_q[tail_idx] <= new_line_hit;
            end
        end
    end

    // Squash pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_valid <= 1'b0;
            squash_tag   <= '0;
        end else begin
            squash_valid <= (retire == RET_SQUASH);
            if (retire == RET_SQUASH) squash_tag <= tag_q[head_idx];
        end
    end

    // Port-side status.
    always_comb begin
        alloc_ready = !ring_full;
        head_valid  = !ring_empty;
        head_tag    = tag_q[head_idx];
    end
endmodule

// File: rtl/slt_checker.sv
// Port-level protocol checks for spec_load_tracker, bound to every instance.
module slt_checker #(
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             commit_valid,
    input logic             head_valid,
    input logic [TAG_W-1:0] head_tag,
    input logic             squash_valid,
    input logic [TAG_W-1:0] squash_tag
);
    p_squash_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !squash_valid);

    p_empty_on_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !head_valid);

    p_squash_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> squash_tag == $past(head_tag));

    p_squash_needs_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(commit_valid && head_valid));

    p_stall_only_when_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |-> head_valid);

    p_commit_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && head_valid) |=> alloc_ready);
endmodule

bind spec_load_tracker slt_checker #(.TAG_W(TAG_W)) u_slt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_ready  (alloc_ready),
    .commit_valid (commit_valid),
    .head_valid   (head_valid),
    .head_tag     (head_tag),
    .squash_valid (squash_valid),
    .squash_tag   (squash_tag)
);

// File: tb/spec_load_tracker_bench.sv
// Scoreboard bench: the driver keeps a queue model and pushes expected
// squash tags; a monitor pops them as squash pulses appear.
module spec_load_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [5:0]  alloc_tag = '0;
    logic        alloc_ready;
    logic        commit_valid = 1'b0;
    logic        head_valid;
    logic [5:0]  head_tag;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        squash_valid;
    logic [5:0]  squash_tag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [25:0] m_line[$];
    logic [5:0]  m_tag[$];
    logic        m_mark[$];
    logic [5:0]  exp_squash[$];

    always #2.5 clk = ~clk;

    spec_load_tracker u_spec_load_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .commit_valid(commit_valid),
        .head_valid(head_valid), .head_tag(head_tag),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .squash_valid(squash_valid), .squash_tag(squash_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare squash pulses against the scoreboard queue (R7, R10).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (squash_valid) begin
                if (exp_squash.size() == 0)
                    check(1'b0, "R10 unexpected squash", int'(squash_tag), -1);
                else
                    check(squash_tag == exp_squash[0], "R7 squash tag",
                          int'(squash_tag), int'(exp_squash[0]));
                if (exp_squash.size() != 0) void'(exp_squash.pop_front());
            end else if (exp_squash.size() != 0) begin
                check(1'b0, "R7 missing squash", 0, int'(exp_squash[0]));
                void'(exp_squash.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus, model update, then port checks (R2, R3).
    task automatic step(input bit av, input logic [31:0] aa, input logic [5:0] at,
                        input bit cv, input bit sv, input logic [31:0] sa, input string req);
        int  sz;
        bit  acc, cfire, sq;
        alloc_valid = av; alloc_addr = aa; alloc_tag = at;
        commit_valid = cv; snoop_valid = sv; snoop_addr = sa;
        sz    = m_line.size();
        acc   = av && (sz < 8);
        cfire = cv && (sz > 0);
        sq    = cfire && (m_mark[0] || (sv && m_line[0] == sa[31:6]));
        @(posedge clk);
        #1;
        if (sq) exp_squash.push_back(m_tag[0]);
        for (int i = 0; i < sz; i++)
            if (sv && m_line[i] == sa[31:6]) m_mark[i] = 1'b1;
        if (sq) begin
            m_line.delete(); m_tag.delete(); m_mark.delete();
        end else begin
            if (cfire) begin
                void'(m_line.pop_front()); void'(m_tag.pop_front()); void'(m_mark.pop_front());
            end
            if (acc) begin
                m_line.push_back(aa[31:6]); m_tag.push_back(at);
                m_mark.push_back(sv && sa[31:6] == aa[31:6]);
            end
        end
        @(negedge clk);
        alloc_valid = 1'b0; commit_valid = 1'b0; snoop_valid = 1'b0;
        check(alloc_ready == (m_line.size() < 8), {req, " R3 ready"},
              int'(alloc_ready), int'(m_line.size() < 8));
        check(head_valid == (m_line.size() > 0), {req, " R2 head_valid"},
              int'(head_valid), int'(m_line.size() > 0));
        if (m_line.size() > 0)
            check(head_tag == m_tag[0], {req, " R2 head_tag"}, int'(head_tag), int'(m_tag[0]));
    endtask

    task automatic idle(input string req);
        step(1'b0, 32'h0, 6'h0, 1'b0, 1'b0, 32'h0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(alloc_ready == 1'b1, "R1 ready", int'(alloc_ready), 1);
        check(head_valid == 1'b0, "R1 head_valid", int'(head_valid), 0);
        check(squash_valid == 1'b0, "R1 squash", int'(squash_valid), 0);
        mon_on = 1'b1;

        // R2/R10: in-order allocate and clean retire.
        for (int i = 1; i <= 3; i++)
            step(1'b1, 32'h100 + 32'(i) * 32'h40, 6'(i), 1'b0, 1'b0, 0, "R2 alloc");
        for (int i = 0; i < 3; i++)
            step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R10 clean commit");

        // R3: fill to capacity, extra request dropped.
        for (int i = 0; i < 8; i++)
            step(1'b1, 32'h1000 + 32'(i) * 32'h40, 6'(10 + i), 1'b0, 1'b0, 0, "R3 fill");
        step(1'b1, 32'h8000, 6'd30, 1'b0, 1'b0, 0, "R3 full drop");
        // R4: offset-only difference hits entry tag 13; far line misses.
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h1000 + 3 * 32'h40 + 32'h3C, "R4 offset hit");
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h9000, "R5 miss keeps mark");
        for (int i = 0; i < 4; i++)
            step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R7 retire to marked");
        idle("R7 after squash");

        // R6: snoop with allocation of same line.
        step(1'b1, 32'h2000, 6'd20, 1'b0, 1'b1, 32'h2010, "R6 same-cycle");
        step(1'b1, 32'h2040, 6'd21, 1'b0, 1'b0, 0, "R6 second");
        step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R6 commit");
        idle("R6 after");

        // R8/R9: snoop at head commit, alloc discarded in squash cycle.
        step(1'b1, 32'h3000, 6'd22, 1'b0, 1'b0, 0, "R8 alloc");
        step(1'b1, 32'h3040, 6'd23, 1'b0, 1'b0, 0, "R8 alloc");
        step(1'b1, 32'h3080, 6'd24, 1'b1, 1'b1, 32'h3000, "R8 R9 commit+snoop");
        idle("R9 after");

        // R9: commit on empty has no effect.
        step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R9 empty commit");
        idle("R9 idle");

        // R5: one snoop marks several entries; flush clears marks.
        step(1'b1, 32'h4000, 6'd30, 1'b0, 1'b0, 0, "R5 alloc");
        step(1'b1, 32'h4080, 6'd31, 1'b0, 1'b0, 0, "R5 alloc");
        step(1'b1, 32'h4004, 6'd32, 1'b0, 1'b0, 0, "R5 alloc");
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h4020, "R5 multi hit");
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h5000, "R5 unrelated");
        step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R5 squash");
        step(1'b1, 32'h4000, 6'd33, 1'b0, 1'b0, 0, "R5 realloc");
        step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R5 clean after flush");

        // R4: bit 6 and top-bit differences do not hit.
        step(1'b1, 32'h6000, 6'd40, 1'b0, 1'b0, 0, "R4 alloc");
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h6040, "R4 bit6");
        step(1'b0, 0, 0, 1'b0, 1'b1, 32'h80006000, "R4 top bit");
        step(1'b0, 0, 0, 1'b1, 1'b0, 0, "R4 clean");

        // R2: back-to-back allocate and retire around the ring.
        step(1'b1, 32'hA000, 6'd1, 1'b0, 1'b0, 0, "R2 prime");
        for (int i = 0; i < 20; i++)
            step(1'b1, 32'hA000 + 32'(i + 1) * 32'h40, 6'(2 + i), 1'b1, 1'b0, 0, "R2 wrap");
        step(1'b0, 0, 0, 1'b1, 1'b1, 32'hA000 + 32'd20 * 32'h40, "R8 wrap squash");
        idle("R7 end");
        idle("R7 end");
        finish_run();
    end
endmodule